// File: doc/BRIEF.md
# Interrupt Enable and Halt Controller

This block sits beside the instruction sequencer of a small 8-bit processor core. It holds three pieces of state:

- the interrupt-enable flag;
- a one-bit delay that arms that flag one instruction late;
- the halt state.

It decides in which cycle an external interrupt request is taken. When a request is taken, the block emits a one-cycle acknowledge together with a request to push the return address. In the same cycle it presents a 16-bit restart vector, formed from the 3-bit restart number that came with the request.

The decoder drives the inputs as single-cycle strobes:

- enable-interrupts, disable-interrupts and halt, one strobe each;
- a pulse in the cycle each instruction completes.

The sequencer uses the acknowledge and push request to save the next-instruction address. It then loads the vector into its program counter. Decode, stack access and the program counter itself live outside this block.

There is no streaming data path. Every pin is a plain level or a single-cycle strobe, with no back-pressure. The acknowledge, push request and vector are registered. Each of them changes one clock after the cycle in which the request is taken.

Top module: `irq_halt_ctrl`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it rises, `int_en`, `halted`, `int_ack` and `push_req` are 0 and `vec_addr` is 0. A reset asserted while halted leaves the halt state.
- R2: An enable strobe arms a pending enable. `int_en` becomes 1 one clock after the first `instr_done` pulse that arrives in a cycle later than the strobe. An `instr_done` pulse in the same cycle as the strobe does not count.
- R3: A disable strobe sets `int_en` to 0 at the next clock. It also cancels a pending enable, and it overrides an enable strobe in the same cycle.
- R4: A halt strobe sets `halted` one clock later. `halted` then stays 1 until an interrupt is taken.
- R5: A request is taken only when all of the following hold in one cycle:
  - `irq_req` is 1;
  - `instr_done` is 1, or the core is halted;
  - interrupts are enabled, either by `int_en` or by a pending enable whose instruction completes in this cycle;
  - no disable strobe is present.
- R6: A taken request gives, one clock later, `int_ack` = 1 and `push_req` = 1 for exactly one cycle. In that same cycle `int_en` is 0, `halted` is 0 and any pending enable is cleared.
- R7: On a taken request with restart number n, `vec_addr` becomes n×8: bits 15..6 are zero, bits 5..3 equal n and bits 2..0 are zero. The value holds until the next taken request.
- R8: While halted with `int_en` at 0, a request is not taken: there is no acknowledge and `halted` stays 1.
- R9: With interrupts enabled but not halted, a request in a cycle without `instr_done` is not taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ei_stb | input | 1 | Enable-interrupts instruction strobe |
| di_stb | input | 1 | Disable-interrupts instruction strobe |
| hlt_stb | input | 1 | Halt instruction strobe |
| instr_done | input | 1 | Instruction-complete pulse |
| irq_req | input | 1 | External interrupt request |
| irq_num | input | 3 | Restart number supplied with the request |
| int_en | output | 1 | Interrupt-enable state |
| halted | output | 1 | Core is halted |
| int_ack | output | 1 | One-cycle interrupt acknowledge |
| push_req | output | 1 | Request to push the return address |
| vec_addr | output | 16 | Restart vector address |

## Verification
Two kinds of state fault show at the ports.

A stale or stuck pending-enable bit shows up as `int_en` rising one instruction early or late. It can also show as a request taken at the wrong boundary. Either way it is visible on the first clock after the deciding `instr_done`.

A wrong halt bit shows as a request taken, or refused, in a cycle without `instr_done`. A wrong vector register shows in `vec_addr` in the same cycle as `int_ack`. Any of these faults is therefore seen within one clock of the stimulus that exposes it.

// File: rtl/ihc_pkg.sv
package ihc_pkg;
  // Instruction-level strobes delivered by the decoder in one cycle.
  typedef struct packed {
    logic ei;
    logic di;
    logic hlt;
    logic done;
  } ihc_strobe_t;
endpackage

// File: rtl/ihc_enable.sv
module ihc_enable
  import ihc_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  ihc_strobe_t stb,
  input  logic        take,
  output logic        ie,
  output logic        ie_eff
);
  logic ie_q;
  logic pend_q;

  // Enabled for acceptance in this cycle: either already on, or the pending
  // enable matures now. A disable strobe wins immediately.
  always_comb ie_eff = ~stb.di & (ie_q | (pend_q & stb.done));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ie_q   <= 1'b0;
      pend_q <= 1'b0;
    end else if (take || stb.di) begin
      ie_q   <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      if (pend_q && stb.done) begin
        ie_q   <= 1'b1;
        pend_q <= 1'b0;
      end
      if (stb.ei) pend_q <= 1'b1;
    end
  end

  assign ie = ie_q;

  // R2: the enable only rises after an instruction completion
  a_r2_rise_after_done: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ie_q) |-> $past(stb.done));
  // R2: an enable strobe never turns the flag on at the next clock by itself
  a_r2_not_immediate: assert property (@(posedge clk) disable iff (!rst_n)
    (stb.ei && !ie_q && !pend_q) |=> !ie_q);
  // R3: disable is immediate
  a_r3_di_clears: assert property (@(posedge clk) disable iff (!rst_n)
    stb.di |=> !ie_q);
endmodule

// File: rtl/ihc_halt.sv
module ihc_halt (
  input  logic clk,
  input  logic rst_n,
  input  logic hlt_stb,
  input  logic take,
  output logic halted
);
  logic halt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       halt_q <= 1'b0;
    else if (take)    halt_q <= 1'b0;
    else if (hlt_stb) halt_q <= 1'b1;
  end

  assign halted = halt_q;

  // R4: halt persists until a request is taken
  a_r4_halt_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (halt_q && !take) |=> halt_q);
endmodule

// File: rtl/ihc_vector.sv
module ihc_vector #(
  parameter int ADDR_W    = 16,
  parameter int NUM_W     = 3,
  parameter int SLOT_LOG2 = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take,
  input  logic [NUM_W-1:0]  num,
  output logic              ack,
  output logic              push,
  output logic [ADDR_W-1:0] vec
);
  localparam int PAD_HI = ADDR_W - NUM_W - SLOT_LOG2;

  logic              ack_q;
  logic [ADDR_W-1:0] vec_q;
  logic [ADDR_W-1:0] vec_next;

  always_comb vec_next = {{PAD_HI{1'b0}}, num, {SLOT_LOG2{1'b0}}};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ack_q <= 1'b0;
      vec_q <= '0;
    end else begin
      ack_q <= take;
      if (take) vec_q <= vec_next;
    end
  end

  assign ack  = ack_q;
  assign push = ack_q;
  assign vec  = vec_q;

  // R6: acknowledge is a single-cycle pulse (enable is cleared on take)
  a_r6_ack_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    ack_q |=> !ack_q);
  // R7: the vector only changes when a request is taken
  a_r7_vec_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(take) |-> $stable(vec_q));
endmodule

// File: rtl/irq_halt_ctrl.sv
module irq_halt_ctrl
  import ihc_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int NUM_W     = 3,
  parameter int SLOT_LOG2 = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ei_stb,
  input  logic              di_stb,
  input  logic              hlt_stb,
  input  logic              instr_done,
  input  logic              irq_req,
  input  logic [NUM_W-1:0]  irq_num,
  output logic              int_en,
  output logic              halted,
  output logic              int_ack,
  output logic              push_req,
  output logic [ADDR_W-1:0] vec_addr
);
  ihc_strobe_t stb;
  logic        ie_eff;
  logic        take;

  always_comb begin
    stb.ei   = ei_stb;
    stb.di   = di_stb;
    stb.hlt  = hlt_stb;
    stb.done = instr_done;
  end

  // Boundary: an instruction just completed, or the core is parked in halt.
  always_comb take = irq_req & (instr_done | halted) & ie_eff;

  ihc_enable u_enable (
    .clk    (clk),
    .rst_n  (rst_n),
    .stb    (stb),
    .take   (take),
    .ie     (int_en),
    .ie_eff (ie_eff)
  );

  ihc_halt u_halt (
    .clk     (clk),
    .rst_n   (rst_n),
    .hlt_stb (stb.hlt),
    .take    (take),
    .halted  (halted)
  );

  ihc_vector #(
    .ADDR_W    (ADDR_W),
    .NUM_W     (NUM_W),
    .SLOT_LOG2 (SLOT_LOG2)
  ) u_vector (
    .clk   (clk),
    .rst_n (rst_n),
    .take  (take),
    .num   (irq_num),
    .ack   (int_ack),
    .push  (push_req),
    .vec   (vec_addr)
  );

  // R5: an acknowledge always answers a request seen on the previous clock
  a_r5_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
    int_ack |-> $past(irq_req));
  // R6: acknowledge leaves interrupts disabled and the core running
  a_r6_ack_state: assert property (@(posedge clk) disable iff (!rst_n)
    int_ack |-> (!int_en && !halted && push_req));
  // R7: vector carries the restart number sampled with the request
  a_r7_vec_num: assert property (@(posedge clk) disable iff (!rst_n)
    int_ack |-> (vec_addr[SLOT_LOG2 +: NUM_W] == $past(irq_num)));
  // R9: no acknowledge without a boundary on the previous clock
  a_r9_boundary: assert property (@(posedge clk) disable iff (!rst_n)
    int_ack |-> ($past(instr_done) || $past(halted)));
endmodule

// File: tb/test_irq_halt_ctrl.sv
module test_irq_halt_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int NROW       = 24;
  localparam int WATCHDOG   = 5000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ei_stb = 1'b0, di_stb = 1'b0, hlt_stb = 1'b0;
  logic        instr_done = 1'b0, irq_req = 1'b0;
  logic [2:0]  irq_num = 3'd0;
  logic        int_en, halted, int_ack, push_req;
  logic [15:0] vec_addr;

  int total = 0;
  int bad   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_halt_ctrl i_irq_halt_ctrl (
    .clk(clk), .rst_n(rst_n), .ei_stb(ei_stb), .di_stb(di_stb),
    .hlt_stb(hlt_stb), .instr_done(instr_done), .irq_req(irq_req),
    .irq_num(irq_num), .int_en(int_en), .halted(halted),
    .int_ack(int_ack), .push_req(push_req), .vec_addr(vec_addr)
  );

  // Row: {req[3:0], ei,di,hlt,done,irq, num[2:0], exp ie,halt,ack, exp vec[15:0]}
  localparam logic [30:0] TBL [NROW] = '{
    {4'd1, 5'b00000, 3'd0, 3'b000, 16'h0000},  // R1 idle after reset
    {4'd2, 5'b10010, 3'd0, 3'b000, 16'h0000},  // R2 EI completes itself
    {4'd9, 5'b00001, 3'd5, 3'b000, 16'h0000},  // R9 request mid-instruction
    {4'd2, 5'b00010, 3'd0, 3'b100, 16'h0000},  // R2 next instr done -> on
    {4'd9, 5'b00001, 3'd2, 3'b100, 16'h0000},  // R9 enabled, no boundary
    {4'd7, 5'b00011, 3'd2, 3'b001, 16'h0010},  // R6 R7 taken, n=2
    {4'd6, 5'b00000, 3'd0, 3'b000, 16'h0010},  // R6 pulse ends, vector held
    {4'd2, 5'b10010, 3'd0, 3'b000, 16'h0010},  // R2 arm again
    {4'd3, 5'b01010, 3'd0, 3'b000, 16'h0010},  // R3 DI cancels pending
    {4'd3, 5'b00010, 3'd0, 3'b000, 16'h0010},  // R3 stays off
    {4'd5, 5'b00011, 3'd7, 3'b000, 16'h0010},  // R5 refused while off
    {4'd2, 5'b10010, 3'd0, 3'b000, 16'h0010},  // R2 arm
    {4'd2, 5'b00010, 3'd0, 3'b100, 16'h0010},  // R2 on
    {4'd3, 5'b01011, 3'd3, 3'b000, 16'h0010},  // R3 R5 DI blocks same-cycle take
    {4'd2, 5'b10010, 3'd0, 3'b000, 16'h0010},  // R2 arm before halt
    {4'd4, 5'b00110, 3'd0, 3'b110, 16'h0010},  // R4 halt, enable matures
    {4'd4, 5'b00000, 3'd0, 3'b110, 16'h0010},  // R4 stays halted
    {4'd4, 5'b00001, 3'd6, 3'b001, 16'h0030},  // R4 R7 taken from halt, n=6
    {4'd6, 5'b00000, 3'd0, 3'b000, 16'h0030},  // R6 running, pulse ends
    {4'd4, 5'b00110, 3'd0, 3'b010, 16'h0030},  // R4 halt with ie off
    {4'd8, 5'b00001, 3'd4, 3'b010, 16'h0030},  // R8 request ignored
    {4'd8, 5'b00000, 3'd0, 3'b010, 16'h0030},  // R8 still halted
    {4'd3, 5'b11010, 3'd0, 3'b010, 16'h0030},  // R3 DI beats EI
    {4'd3, 5'b00010, 3'd0, 3'b010, 16'h0030}   // R3 nothing pending
  };

  task automatic check(input int req, input logic [18:0] exp, input int row);
    logic [18:0] act;
    act = {int_en, halted, int_ack, vec_addr};
    total++;
    if (act !== exp || push_req !== exp[16]) begin
      bad++;
      $display("FAIL R%0d row %0d: got ie=%b halt=%b ack=%b push=%b vec=%h, expected ie=%b halt=%b ack=%b push=%b vec=%h",
               req, row, act[18], act[17], act[16], push_req, act[15:0],
               exp[18], exp[17], exp[16], exp[16], exp[15:0]);
    end
  endtask

  // Drive at a falling edge, then check at the next falling edge.
  task automatic step(input logic [7:0] stim, input logic [18:0] exp,
                      input int req, input int row);
    {ei_stb, di_stb, hlt_stb, instr_done, irq_req, irq_num} = stim;
    @(negedge clk);
    check(req, exp, row);
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    @(negedge clk);
    @(negedge clk);
    check(1, 19'h0, 100);                 // R1 outputs during reset
    rst_n = 1'b1;
    @(negedge clk);
    check(1, 19'h0, 101);                 // R1 first cycle after release

    for (int i = 0; i < NROW; i++)
      step(TBL[i][26:19], TBL[i][18:0], int'(TBL[i][30:27]), i);

    // R1: reset while halted leaves halt
    rst_n = 1'b0;
    {ei_stb, di_stb, hlt_stb, instr_done, irq_req, irq_num} = '0;
    @(negedge clk);
    check(1, 19'h0, 200);
    rst_n = 1'b1;
    @(negedge clk);
    check(1, 19'h0, 201);

    // R7: highest restart number, n=7 -> 0x0038
    step(8'b10010_000, {3'b000, 16'h0000}, 2, 202);
    step(8'b00010_000, {3'b100, 16'h0000}, 2, 203);
    step(8'b00011_111, {3'b001, 16'h0038}, 7, 204);
    step(8'b00000_000, {3'b000, 16'h0038}, 6, 205);
    // R7: lowest restart number, n=0 -> 0x0000
    step(8'b10010_000, {3'b000, 16'h0038}, 2, 206);
    step(8'b00010_000, {3'b100, 16'h0038}, 2, 207);
    step(8'b00011_000, {3'b001, 16'h0000}, 7, 208);
    // R2: EI while a pending enable matures keeps the flag on
    step(8'b10010_000, {3'b000, 16'h0000}, 2, 209);
    step(8'b10010_000, {3'b100, 16'h0000}, 2, 210);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule